// File: doc/BRIEF.md
# Wake-Up Event and Interrupt Controller

This block gathers five wake-up sources of different kinds, holds each one in a sticky status bit, and pulls an active-low interrupt line to a host. The host shifts out the status word through its serial port to learn which source fired. The read strobe, raised for one cycle during that access, clears the latched bits. The serial shift logic and the sources themselves sit outside the block. The block only sees their outputs as inputs synchronous to `clk`, except for the external pin, which it synchronizes itself.

The sources are handled as follows. A falling edge on the external active-low pin sets a flag. So does a rising edge of the low-supply comparator output. The timer timeout, the FIFO-filled condition and the host request set their flags on every cycle in which they are high. A per-source enable vector decides which flags may drive the interrupt line. A disabled source is still recorded in the status word.

The interrupt line is driven by a two-state machine. The state `IRQ_IDLE` drives the line high. The transition `go_active` happens when any enabled flag is set, and moves to `IRQ_ACTIVE`, which drives the line low. The transition `go_idle` happens when no enabled flag remains, and returns to `IRQ_IDLE`.

Top module: `wake_event_ctrl`

## Requirements
- R1: While reset is asserted and after it is released with all sources idle, `status` is 5'b00000 and `irq_n` is 1.
- R2: `status[0]` records the external pin. It is set on the third rising clock edge after `ext_int_n` falls, because of two synchronizer flops and one edge-detect stage. A pin held low, or a rising edge of the pin, does not set it again.
- R3: `status[1]` (timer timeout) and `status[4]` (host request) are set on the clock edge that follows any cycle in which `timer_expire` or `host_req` is 1.
- R4: `status[2]` (low supply) is set on the edge that follows a cycle in which `supply_low` is 1 after being 0 in the previous cycle. If `supply_low` stays high, it does not set the flag again after a read.
- R5: `status[3]` (FIFO filled) is set on the edge that follows every cycle in which `fifo_full` is 1. It is therefore set again right after a read if the input stays high.
- R6: A set status bit stays set until a read.
- R7: During the cycle in which `stat_rd` is 1, `status` shows the word being read. On the next edge every bit clears, except a bit whose source event occurs in that same cycle, which stays set for the next read.
- R8: `irq_enable[i]` controls `status[i]`, where 1 means enabled. `irq_n` goes low on the edge after any cycle in which `status & irq_enable` is nonzero.
- R9: A source whose enable bit is 0 still sets its status bit, but does not drive `irq_n` low.
- R10: `irq_n` returns to 1 on the edge after the first cycle in which `status & irq_enable` is zero. This happens after a read or after the enables are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_int_n | input | 1 | External active-low interrupt pin, asynchronous |
| timer_expire | input | 1 | Wake-up timer timeout |
| supply_low | input | 1 | Low-supply comparator output (level) |
| fifo_full | input | 1 | Receive FIFO filled condition |
| host_req | input | 1 | Wake request from the serial interface |
| irq_enable | input | 5 | Per-source interrupt enables, bit i controls status bit i |
| stat_rd | input | 1 | One-cycle status read strobe; clears flags |
| status | output | 5 | Latched source flags: 0 pin, 1 timer, 2 supply, 3 FIFO, 4 host |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check the following properties on every cycle:
- The interrupt line follows the enabled flags of the previous cycle.
- Flags stay set while no read occurs.
- Flags of the level and pulse sources set on the next edge, and the supply flag sets on a rising edge.
- A read clears a flag whose source is quiet.

Some behaviours can only be shown by the bench scenarios:
- The three-edge latency of the synchronized pin.
- A pin held low, or a supply level held high, setting nothing more after a read.
- An event that arrives in the read cycle surviving the read.
- The interrupt line moving when the enables change while the flags stay put.

// File: rtl/wk_pkg.sv
package wk_pkg;
    localparam int NUM_SRC   = 5;
    localparam int SRC_PIN   = 0;
    localparam int SRC_TIMER = 1;
    localparam int SRC_SUPPLY = 2;
    localparam int SRC_FIFO  = 3;
    localparam int SRC_HOST  = 4;

    typedef enum logic [0:0] {
        IRQ_IDLE   = 1'b0,
        IRQ_ACTIVE = 1'b1
    } irq_state_e;
endpackage

// File: rtl/wk_pin_sync.sv
module wk_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic fall
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    // chain[STAGES-1] is the synchronized pin, chain[STAGES] its previous value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[LAST-1:0], pin_n};
        end
    end

    assign fall = chain[LAST] & ~chain[LAST-1];
endmodule

// File: rtl/wk_flag_bank.sv
module wk_flag_bank #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         clr,
    output logic [N-1:0] flags
);
    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_flag
            // an event in the clearing cycle wins, so it is kept for the next read
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    flags[i] <= 1'b0;
                end else if (set_evt[i]) begin
                    flags[i] <= 1'b1;
                end else if (clr) begin
                    flags[i] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/wk_irq_fsm.sv
module wk_irq_fsm
    import wk_pkg::*;
#(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] enable,
    output logic         irq_n
);
    irq_state_e state_q, state_d;
    logic       pending;

    assign pending = |(flags & enable);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (pending)  state_d = IRQ_ACTIVE; // go_active
            IRQ_ACTIVE: if (!pending) state_d = IRQ_IDLE;   // go_idle
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            IRQ_IDLE:   irq_n = 1'b1;
            IRQ_ACTIVE: irq_n = 1'b0;
            default:    irq_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
    import wk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_int_n,
    input  logic               timer_expire,
    input  logic               supply_low,
    input  logic               fifo_full,
    input  logic               host_req,
    input  logic [NUM_SRC-1:0] irq_enable,
    input  logic               stat_rd,
    output logic [NUM_SRC-1:0] status,
    output logic               irq_n
);
    logic               pin_fall;
    logic               supply_q;
    logic               supply_rise;
    logic [NUM_SRC-1:0] set_vec;

    wk_pin_sync #(.STAGES(SYNC_STAGES)) u_pin (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_n (ext_int_n),
        .fall  (pin_fall)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            supply_q <= 1'b0;
        end else begin
            supply_q <= supply_low;
        end
    end

    assign supply_rise = supply_low & ~supply_q;

    always_comb begin
        set_vec             = '0;
        set_vec[SRC_PIN]    = pin_fall;
        set_vec[SRC_TIMER]  = timer_expire;
        set_vec[SRC_SUPPLY] = supply_rise;
        set_vec[SRC_FIFO]   = fifo_full;
        set_vec[SRC_HOST]   = host_req;
    end

    wk_flag_bank #(.N(NUM_SRC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (set_vec),
        .clr     (stat_rd),
        .flags   (status)
    );

    wk_irq_fsm #(.N(NUM_SRC)) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags  (status),
        .enable (irq_enable),
        .irq_n  (irq_n)
    );
endmodule

// File: rtl/wake_event_ctrl_chk.sv
module wake_event_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       timer_expire,
    input logic       supply_low,
    input logic       fifo_full,
    input logic       host_req,
    input logic       stat_rd,
    input logic [4:0] irq_enable,
    input logic [4:0] status,
    input logic       irq_n
);
    AST_IRQ_TRACKS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_n == !(|($past(status & irq_enable))))); // R8

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_rd |=> ((status & $past(status)) == $past(status))); // R6

    AST_TIMER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        timer_expire |=> status[1]); // R3

    AST_HOST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        host_req |=> status[4]); // R3

    AST_FIFO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |=> status[3]); // R5

    AST_SUPPLY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_low && !$past(supply_low)) |=> status[2]); // R4

    AST_READ_CLEARS_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !timer_expire) |=> !status[1]); // R7

    AST_READ_CLEARS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !fifo_full) |=> !status[3]); // R7

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & irq_enable) == 5'b0) |=> irq_n); // R9
endmodule

bind wake_event_ctrl wake_event_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .timer_expire (timer_expire),
    .supply_low   (supply_low),
    .fifo_full    (fifo_full),
    .host_req     (host_req),
    .stat_rd      (stat_rd),
    .irq_enable   (irq_enable),
    .status       (status),
    .irq_n        (irq_n)
);

// File: tb/wake_event_ctrl_test.sv
module wake_event_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_int_n = 1'b1;
    logic       timer_expire = 1'b0;
    logic       supply_low = 1'b0;
    logic       fifo_full = 1'b0;
    logic       host_req = 1'b0;
    logic [4:0] irq_enable = 5'b11111;
    logic       stat_rd = 1'b0;
    logic [4:0] status;
    logic       irq_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wake_event_ctrl uut (
        .clk(clk), .rst_n(rst_n), .ext_int_n(ext_int_n),
        .timer_expire(timer_expire), .supply_low(supply_low),
        .fifo_full(fifo_full), .host_req(host_req),
        .irq_enable(irq_enable), .stat_rd(stat_rd),
        .status(status), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // read: word visible during strobe cycle, cleared afterwards
    task automatic do_read(input logic [4:0] exp_word, input string req);
        stat_rd = 1'b1;
        check(req, status, exp_word);
        tick();
        stat_rd = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 status in reset", status, 5'b0);
        check("R1 irq_n in reset", {4'b0, irq_n}, 5'b1);
        rst_n = 1'b1;
        tick(3);
        check("R1 status after reset", status, 5'b0);
        check("R1 irq_n after reset", {4'b0, irq_n}, 5'b1);
    endtask

    task automatic t_ext_pin();
        ext_int_n = 1'b0;
        tick(2);
        check("R2 no flag after two edges", status, 5'b0);
        tick();
        check("R2 pin flag on third edge", status, 5'b00001);
        check("R8 irq_n still high", {4'b0, irq_n}, 5'b1);
        tick();
        check("R8 irq_n low after flag", {4'b0, irq_n}, 5'b0);
        tick(3);
        check("R6 pin flag sticky", status, 5'b00001);
        do_read(5'b00001, "R7 read word pin");
        check("R7 cleared after read", status, 5'b0);
        tick(3);
        check("R2 held low no reset", status, 5'b0);
        ext_int_n = 1'b1;
        tick(4);
        check("R2 rising edge ignored", status, 5'b0);
        check("R10 irq_n released", {4'b0, irq_n}, 5'b1);
    endtask

    task automatic t_timer_host();
        timer_expire = 1'b1;
        tick();
        timer_expire = 1'b0;
        check("R3 timer flag", status, 5'b00010);
        host_req = 1'b1;
        tick();
        host_req = 1'b0;
        check("R3 host flag", status, 5'b10010);
        do_read(5'b10010, "R7 read word timer host");
        check("R7 cleared timer host", status, 5'b0);
        tick(2);
    endtask

    task automatic t_supply();
        supply_low = 1'b1;
        tick();
        check("R4 supply rise flag", status, 5'b00100);
        do_read(5'b00100, "R7 read word supply");
        tick(3);
        check("R4 held high no reset", status, 5'b0);
        supply_low = 1'b0;
        tick(2);
        supply_low = 1'b1;
        tick();
        check("R4 second rise flag", status, 5'b00100);
        supply_low = 1'b0;
        do_read(5'b00100, "R7 read word supply2");
        tick(2);
    endtask

    task automatic t_fifo();
        fifo_full = 1'b1;
        tick();
        check("R5 fifo flag", status, 5'b01000);
        do_read(5'b01000, "R7 read word fifo");
        check("R5 fifo reset while high", status, 5'b01000);
        fifo_full = 1'b0;
        do_read(5'b01000, "R7 read word fifo2");
        check("R5 fifo cleared when low", status, 5'b0);
        tick(2);
    endtask

    task automatic t_collide();
        timer_expire = 1'b1;
        tick();
        timer_expire = 1'b0;
        host_req = 1'b1;
        stat_rd = 1'b1;
        check("R7 word before collision", status, 5'b00010);
        tick();
        stat_rd = 1'b0;
        host_req = 1'b0;
        check("R7 event in read cycle kept", status, 5'b10000);
        do_read(5'b10000, "R7 read kept event");
        tick(2);
    endtask

    task automatic t_mask();
        irq_enable = 5'b11101;
        timer_expire = 1'b1;
        tick();
        timer_expire = 1'b0;
        check("R9 masked source sets status", status, 5'b00010);
        tick(2);
        check("R9 masked source no irq", {4'b0, irq_n}, 5'b1);
        irq_enable = 5'b00010;
        tick();
        check("R8 enable raises irq", {4'b0, irq_n}, 5'b0);
        irq_enable = 5'b0;
        tick();
        check("R10 clearing enable releases irq", {4'b0, irq_n}, 5'b1);
        irq_enable = 5'b11111;
        tick();
        check("R8 irq back on", {4'b0, irq_n}, 5'b0);
        do_read(5'b00010, "R7 read word mask");
        check("R10 irq held one edge after read", {4'b0, irq_n}, 5'b0);
        tick();
        check("R10 irq released after read", {4'b0, irq_n}, 5'b1);
    endtask

    initial begin
        t_reset();
        t_ext_pin();
        t_timer_host();
        t_supply();
        t_fifo();
        t_collide();
        t_mask();
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule